// File: doc/BRIEF.md
# Vector Scatter/Gather Sequencer

This block turns one indexed vector memory operation into a series of single-word accesses on a scalar memory port. It accepts a vector of four 32-bit element indices, a scalar base address and an element enable mask. Each enabled element gets its own address, which is the base plus that element's index, so the elements need not be at consecutive addresses. A gather reads one word per enabled element and places it in the matching element of a result vector. A scatter writes the matching element of a data vector to each address.

Each access goes out on a request/grant port and is held until memory accepts it. Gather read data returns later, in the same order as the requests, on a separate valid strobe. The whole operation therefore takes several cycles, unlike a unit-stride access that moves the full vector in one wide transfer. A busy flag covers the operation, and a one-cycle done strobe marks its end.

Top module: `sgs_top`

## Requirements
- R1: The address issued for element i is `base + idx_vec[i*32 +: 32]`, taken modulo 2^32.
- R2: One request is issued for each enabled element, in ascending element order. `op` = 1 selects scatter: `mem_we` = 1 and `mem_wdata` = `wdata_vec[i*32 +: 32]`. `op` = 0 selects gather: `mem_we` = 0.
- R3: While `mem_req` is high and `mem_gnt` is low, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` hold their values. The sequence moves to the next element only on a granted cycle.
- R4: For a gather, the k-th `mem_rvalid` of the operation writes `mem_rdata` into `result[i*32 +: 32]`, where i is the k-th enabled element.
- R5: A masked-off element (mask bit 0) issues no request, and its result element keeps its previous value. A scatter never changes `result`. `mem_rvalid` and `mem_gnt` have no effect when nothing is outstanding.
- R6: `done` is a one-cycle pulse. For a scatter it is high in the cycle after the grant of the last enabled element. For a gather it is high in the cycle after the read data for the last enabled element. `busy` is low in the done cycle.
- R7: A `start` is accepted only when `busy` is low. `busy` is high from the cycle after an accepted start with a nonzero mask until `done`. A `start` seen while busy has no effect on requests, result or timing.
- R8: With an all-zero mask, `done` is high in the cycle after the start. No request is issued and `busy` stays low.
- R9: After reset, `busy`, `done` and `mem_req` are low and `result` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch strobe |
| op | input | 1 | 1 = scatter, 0 = gather |
| base | input | 32 | Scalar base address |
| idx_vec | input | 128 | Element indices, element i at bits [i*32 +: 32] |
| wdata_vec | input | 128 | Scatter data, element i at bits [i*32 +: 32] |
| mask | input | 4 | Element enables |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Request address |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Memory accepts the current request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished (one cycle) |
| result | output | 128 | Gathered vector, element i at bits [i*32 +: 32] |

## Verification
During a gather, the issue path and the collect path work at the same time. The grant of element k+1 can land in the same cycle as the read data of element k. The bench forces this overlap with runs where memory grants every cycle and answers one cycle after each grant. It then checks the request order and addresses on every handshake and the gathered vector at done. Random grant and response rates mix the overlapping cycles with stalled ones, and every result element is compared against a value the bench computes from its own memory image.

// File: rtl/sgs_pkg.sv
package sgs_pkg;
  typedef enum logic {
    SG_GATHER  = 1'b0,
    SG_SCATTER = 1'b1
  } sg_op_e;
endpackage

// File: rtl/sgs_first_lane.sv
// Lowest-numbered set bit of a lane vector: fixes ascending element order.
module sgs_first_lane #(
  parameter int NL = 4,
  localparam int LW = (NL > 1) ? $clog2(NL) : 1
) (
  input  logic [NL-1:0] vec,
  output logic          found,
  output logic [LW-1:0] lane
);
  always_comb begin
    found = 1'b0;
    lane  = '0;
    for (int i = NL - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        lane  = LW'(i);
      end
    end
  end
endmodule

// File: rtl/sgs_issue.sv
// Request side: walks the enabled elements and drives the scalar port.
module sgs_issue
  import sgs_pkg::*;
#(
  parameter int NL = 4,
  parameter int AW = 32,
  parameter int IW = 32,
  parameter int DW = 32,
  localparam int LW = (NL > 1) ? $clog2(NL) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           launch,
  input  sg_op_e         launch_op,
  input  logic [NL-1:0]  launch_mask,
  input  logic [AW-1:0]  launch_base,
  input  logic [NL*IW-1:0] launch_idx,
  input  logic [NL*DW-1:0] launch_wdata,
  input  logic           mem_gnt,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  output logic           last_grant
);
  logic [NL-1:0]    pend_q;
  logic [LW-1:0]    cur_lane;
  logic [AW-1:0]    base_q;
  logic [NL*IW-1:0] idx_q;
  logic [NL*DW-1:0] wd_q;

  logic [NL-1:0]    cand;
  logic             nxt_found;
  logic [LW-1:0]    nxt_lane;
  logic [IW-1:0]    idx_sel;
  logic [DW-1:0]    wd_sel;
  logic [AW-1:0]    nxt_addr;
  logic             granted;

  assign granted = mem_req && mem_gnt;

  always_comb begin
    if (launch) cand = launch_mask;
    else        cand = pend_q & ~(NL'(1) << cur_lane);
  end

  sgs_first_lane #(.NL(NL)) u_pick (
    .vec   (cand),
    .found (nxt_found),
    .lane  (nxt_lane)
  );

  always_comb begin
    if (launch) begin
      idx_sel  = launch_idx[int'(nxt_lane)*IW +: IW];
      wd_sel   = launch_wdata[int'(nxt_lane)*DW +: DW];
      nxt_addr = launch_base + AW'(idx_sel);
    end else begin
      idx_sel  = idx_q[int'(nxt_lane)*IW +: IW];
      wd_sel   = wd_q[int'(nxt_lane)*DW +: DW];
      nxt_addr = base_q + AW'(idx_sel);
    end
  end

  assign last_grant = granted && !nxt_found;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= '0;
      cur_lane  <= '0;
      base_q    <= '0;
      idx_q     <= '0;
      wd_q      <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (launch) begin
      base_q    <= launch_base;
      idx_q     <= launch_idx;
      wd_q      <= launch_wdata;
      pend_q    <= launch_mask;
      mem_we    <= (launch_op == SG_SCATTER);
      mem_req   <= nxt_found;
      cur_lane  <= nxt_lane;
      mem_addr  <= nxt_addr;
      mem_wdata <= wd_sel;
    end else if (granted) begin
      pend_q  <= cand;
      mem_req <= nxt_found;
      if (nxt_found) begin
        cur_lane  <= nxt_lane;
        mem_addr  <= nxt_addr;
        mem_wdata <= wd_sel;
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R3
endmodule

// File: rtl/sgs_collect.sv
// Response side: steers in-order read data into the result lanes.
module sgs_collect #(
  parameter int NL = 4,
  parameter int DW = 32,
  localparam int LW = (NL > 1) ? $clog2(NL) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic             launch_gather,
  input  logic [NL-1:0]    launch_mask,
  input  logic             mem_rvalid,
  input  logic [DW-1:0]    mem_rdata,
  output logic [NL*DW-1:0] result,
  output logic             last_resp
);
  logic [NL-1:0] rpend_q;
  logic          head_found;
  logic [LW-1:0] head_lane;
  logic          take;
  logic [NL-1:0] head_oh;

  sgs_first_lane #(.NL(NL)) u_head (
    .vec   (rpend_q),
    .found (head_found),
    .lane  (head_lane)
  );

  assign take      = mem_rvalid && head_found;
  assign head_oh   = NL'(1) << head_lane;
  assign last_resp = take && ((rpend_q & ~head_oh) == '0);

  always_ff @(posedge clk) begin
    if (rst)              rpend_q <= '0;
    else if (launch)      rpend_q <= launch_gather ? launch_mask : '0;
    else if (take)        rpend_q <= rpend_q & ~head_oh;
  end

  for (genvar g = 0; g < NL; g++) begin : g_lane
    logic [DW-1:0] lane_q;
    always_ff @(posedge clk) begin
      if (rst)                                   lane_q <= '0;
      else if (take && (head_lane == LW'(g)))    lane_q <= mem_rdata;
    end
    assign result[g*DW +: DW] = lane_q;
  end

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !mem_rvalid |=> $stable(result)); // R5
endmodule

// File: rtl/sgs_top.sv
module sgs_top
  import sgs_pkg::*;
#(
  parameter int NL = 4,
  parameter int AW = 32,
  parameter int IW = 32,
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             op,
  input  logic [AW-1:0]    base,
  input  logic [NL*IW-1:0] idx_vec,
  input  logic [NL*DW-1:0] wdata_vec,
  input  logic [NL-1:0]    mask,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic             mem_gnt,
  input  logic             mem_rvalid,
  input  logic [DW-1:0]    mem_rdata,
  output logic             busy,
  output logic             done,
  output logic [NL*DW-1:0] result
);
  sg_op_e op_in;
  sg_op_e op_q;
  logic   accept;
  logic   last_grant;
  logic   last_resp;
  logic   finish;

  assign op_in  = sg_op_e'(op);
  assign accept = start && !busy;
  assign finish = (op_q == SG_SCATTER) ? last_grant : last_resp;

  sgs_issue #(.NL(NL), .AW(AW), .IW(IW), .DW(DW)) u_issue (
    .clk          (clk),
    .rst          (rst),
    .launch       (accept),
    .launch_op    (op_in),
    .launch_mask  (mask),
    .launch_base  (base),
    .launch_idx   (idx_vec),
    .launch_wdata (wdata_vec),
    .mem_gnt      (mem_gnt),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .last_grant   (last_grant)
  );

  sgs_collect #(.NL(NL), .DW(DW)) u_collect (
    .clk           (clk),
    .rst           (rst),
    .launch        (accept),
    .launch_gather (op_in == SG_GATHER),
    .launch_mask   (mask),
    .mem_rvalid    (mem_rvalid),
    .mem_rdata     (mem_rdata),
    .result        (result),
    .last_resp     (last_resp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      op_q <= SG_GATHER;
    end else begin
      done <= 1'b0;
      if (accept) begin
        op_q <= op_in;
        if (mask == '0) done <= 1'b1;
        else            busy <= 1'b1;
      end else if (busy && finish) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  AST_ZERO_MASK: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (mask == '0)) |=> (done && !busy && !mem_req)); // R8
  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (mask != '0)) |=> (busy && mem_req)); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !mem_req)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> !done); // R6
  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req); // R7
endmodule

// File: tb/sim_sgs_top.sv
module sim_sgs_top;
  localparam int NL = 4;
  localparam int AW = 32;
  localparam int IW = 32;
  localparam int DW = 32;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic             op = 1'b0;
  logic [AW-1:0]    base = '0;
  logic [NL*IW-1:0] idx_vec = '0;
  logic [NL*DW-1:0] wdata_vec = '0;
  logic [NL-1:0]    mask = '0;
  logic             mem_req, mem_we;
  logic [AW-1:0]    mem_addr;
  logic [DW-1:0]    mem_wdata;
  logic             mem_gnt = 1'b0;
  logic             mem_rvalid = 1'b0;
  logic [DW-1:0]    mem_rdata = '0;
  logic             busy, done;
  logic [NL*DW-1:0] result;

  always #2 clk = ~clk;

  sgs_top #(.NL(NL), .AW(AW), .IW(IW), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .start(start), .op(op), .base(base),
    .idx_vec(idx_vec), .wdata_vec(wdata_vec), .mask(mask),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .result(result)
  );

  int checks = 0;
  int fails  = 0;
  int pcyc   = 0;
  int fin_due = -1;

  logic [DW-1:0]    mem [256];
  logic [DW-1:0]    rq [$];
  logic [AW-1:0]    e_addr [NL];
  logic [DW-1:0]    e_wd [NL];
  logic             e_we = 1'b0;
  int               e_n = 0;
  int               acc_n = 0;
  int               gnt_pct = 100;
  int               rv_pct = 100;
  logic             hold_pend = 1'b0;
  logic [AW-1:0]    hold_addr = '0;
  logic [NL*DW-1:0] res_model = '0;

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] init_word(input int a);
    return DW'(a * 32'h9E37_79B9) ^ 32'h1234_5678;
  endfunction

  always @(posedge clk) pcyc <= pcyc + 1;

  always @(posedge clk) begin
    if (pcyc > 150000) begin
      check(1'b0, "watchdog", 128'(pcyc), 128'd150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // Memory model: decides grant and read return at the falling edge.
  always @(negedge clk) begin
    if (rst) begin
      mem_gnt    = 1'b0;
      mem_rvalid = 1'b0;
      rq.delete();
      hold_pend  = 1'b0;
    end else begin
      if (hold_pend)
        check(mem_req && (mem_addr == hold_addr), "R3 request held until grant",
              128'(mem_addr), 128'(hold_addr));
      if (rq.size() > 0 && int'($urandom % 100) < rv_pct) begin
        mem_rvalid = 1'b1;
        mem_rdata  = rq.pop_front();
        if (rq.size() == 0 && acc_n == e_n && !e_we) fin_due = pcyc + 1;
      end else begin
        mem_rvalid = 1'b0;
        mem_rdata  = $urandom;
      end
      if (mem_req && int'($urandom % 100) < gnt_pct) begin
        mem_gnt = 1'b1;
        if (acc_n < e_n) begin
          check(mem_addr == e_addr[acc_n], "R1 element address", 128'(mem_addr), 128'(e_addr[acc_n]));
          check(mem_we == e_we, "R2 access direction", 128'(mem_we), 128'(e_we));
          if (e_we)
            check(mem_wdata == e_wd[acc_n], "R2 scatter data order", 128'(mem_wdata), 128'(e_wd[acc_n]));
        end else begin
          check(1'b0, "R5 request beyond enabled elements", 128'(acc_n), 128'(e_n));
        end
        if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
        else        rq.push_back(mem[mem_addr[7:0]]);
        acc_n++;
        if (e_we && acc_n == e_n) fin_due = pcyc + 1;
      end else begin
        mem_gnt = mem_req ? 1'b0 : 1'($urandom);
      end
      hold_pend = mem_req && !mem_gnt;
      hold_addr = mem_addr;
    end
  end

  task automatic run_op(input bit o, input logic [AW-1:0] b, input logic [NL*IW-1:0] ix,
                        input logic [NL*DW-1:0] wd, input logic [NL-1:0] m, input bit poke);
    logic [NL*DW-1:0] exp_res;
    int cyc;
    e_n = 0;
    exp_res = res_model;
    for (int i = 0; i < NL; i++) begin
      if (m[i]) begin
        e_addr[e_n] = b + ix[i*IW +: IW];
        e_wd[e_n]   = wd[i*DW +: DW];
        if (!o) exp_res[i*DW +: DW] = mem[e_addr[e_n][7:0]];
        e_n++;
      end
    end
    e_we = o;
    acc_n = 0;
    fin_due = -1;
    @(negedge clk);
    start = 1'b1; op = o; base = b; idx_vec = ix; wdata_vec = wd; mask = m;
    @(negedge clk);
    start = 1'b0; op = 1'($urandom); base = $urandom; mask = 4'($urandom);
    idx_vec = {$urandom, $urandom, $urandom, $urandom};
    if (m == '0) begin
      check(done == 1'b1, "R8 zero mask done next cycle", 128'(done), 128'd1);
      check(busy == 1'b0 && mem_req == 1'b0, "R8 zero mask no busy/request",
            128'({busy, mem_req}), 128'd0);
      @(negedge clk);
      check(done == 1'b0 && acc_n == 0, "R8 zero mask single pulse, no access",
            128'({done, 8'(acc_n)}), 128'd0);
      check(result == res_model, "R5 zero mask result unchanged", result, res_model);
      return;
    end
    check(busy == 1'b1, "R7 busy after start", 128'(busy), 128'd1);
    cyc = 0;
    while (!done && cyc < 1000) begin
      if (poke && cyc == 0) begin
        start = 1'b1; op = ~o; mask = '1; base = $urandom;
        @(negedge clk);
        start = 1'b0;
      end else begin
        @(negedge clk);
      end
      cyc++;
      if (!done)
        check(busy == 1'b1, "R7 busy until done", 128'(busy), 128'd1);
    end
    check(done == 1'b1, "R6 done reached", 128'(done), 128'd1);
    check(pcyc == fin_due, "R6 done one cycle after last event", 128'(pcyc), 128'(fin_due));
    check(busy == 1'b0, "R6 busy low with done", 128'(busy), 128'd0);
    check(acc_n == e_n, "R2 one access per enabled element", 128'(acc_n), 128'(e_n));
    if (o) check(result == res_model, "R5 scatter leaves result", result, res_model);
    else   check(result == exp_res, "R4 gathered vector", result, exp_res);
    res_model = exp_res;
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0 && mem_req == 1'b0, "R7 no relaunch from ignored start",
          128'({done, busy, mem_req}), 128'd0);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int a = 0; a < 256; a++) mem[a] = init_word(a);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && mem_req == 1'b0, "R9 reset outputs",
          128'({busy, done, mem_req}), 128'd0);
    check(result == '0, "R9 reset result", result, 128'd0);

    // Full gather, memory answers every cycle: grant and return overlap.
    gnt_pct = 100; rv_pct = 100;
    run_op(1'b0, 32'h0000_0100, {32'd12, 32'd8, 32'd4, 32'd0}, '0, 4'b1111, 1'b0);
    // Zero mask, both directions.
    run_op(1'b0, 32'h10, {32'd1, 32'd2, 32'd3, 32'd4}, '0, 4'b0000, 1'b0);
    run_op(1'b1, 32'h10, {32'd1, 32'd2, 32'd3, 32'd4}, {4{32'hDEAD_BEEF}}, 4'b0000, 1'b0);
    // Scatter with repeated index: the higher element lands last.
    run_op(1'b1, 32'h40, {32'd5, 32'd5, 32'd1, 32'd5},
           {32'hAAAA_0003, 32'hAAAA_0002, 32'hAAAA_0001, 32'hAAAA_0000}, 4'b1111, 1'b0);
    run_op(1'b0, 32'h40, {32'd0, 32'd0, 32'd1, 32'd5}, '0, 4'b0011, 1'b0);
    check(result[31:0] == 32'hAAAA_0003, "R2 later element wins on repeated index",
          128'(result[31:0]), 128'h0000_0000_0000_0000_0000_0000_AAAA_0003);
    // Address wrap and partial mask with skipped lanes.
    gnt_pct = 40; rv_pct = 50;
    run_op(1'b0, 32'hFFFF_FFF0, {32'h20, 32'h11, 32'h10, 32'h30}, '0, 4'b1010, 1'b1);
    // Only the last element enabled, with a start poked while busy.
    run_op(1'b1, 32'h80, {32'd7, 32'd0, 32'd0, 32'd0}, {32'h5555_1234, 96'd0}, 4'b1000, 1'b1);

    for (int n = 0; n < 80; n++) begin
      logic [NL-1:0] m;
      gnt_pct = 30 + int'($urandom % 71);
      rv_pct  = 30 + int'($urandom % 71);
      m = (n % 11 == 5) ? 4'b0000 : 4'($urandom);
      run_op(1'($urandom), $urandom, {($urandom & 32'h1FF), ($urandom & 32'h1FF),
             ($urandom & 32'h1FF), ($urandom & 32'h1FF)},
             {$urandom, $urandom, $urandom, $urandom}, m, (($urandom % 4) == 0));
    end

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule